// File: doc/BRIEF.md
# Encoder Input Conditioner with Programmable Sample Rate

This block is the front end for one incremental encoder channel. A programmable divider turns the fast master clock into a slower sampling tick. The phase A, phase B and index lines are sampled on that tick, and noise on them is rejected. The cleaned phase signals are then decoded into a one-cycle count pulse and a direction level. A downstream position counter consumes both outputs.

The divider ratio is an 8-bit value n. The tick repeats every n+1 master cycles, and n = 0 gives a tick on every cycle. Writing a new n through the load strobe restarts the division from that moment. A line is accepted as changed only after a fixed number of consecutive ticks sample its new level. This sets the shortest pulse and the shortest phase separation the block accepts, and it gives a bounded delay from an input edge to a count pulse. The resolution can be one, two or four counts per encoder cycle.

Top module: `qenc_front`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `cnt_en`, `cnt_up` and `idx_valid` are 0. After reset the divider value is 0.
- R2: With a stored divider value n (0..255), the sampling tick repeats every n+1 master cycles.
- R3: A load strobe stores `psc_value` and restarts the division. Suppose the strobe and a settled edge on `quad_a` are both applied in the same cycle, with n = 1 and FILT_LEN = 3. Then `cnt_en` is first seen high 9 cycles later.
- R4: A level on any input that lasts at most (FILT_LEN-1)·(n+1) master cycles is ignored and produces no count.
- R5: Take a settled `quad_a` edge applied after the divider has been running. `cnt_en` is first seen high between 4+(FILT_LEN-1)·(n+1) and 4+n+(FILT_LEN-1)·(n+1) master cycles later.
- R6: In mode 2'b10 or 2'b11, every accepted phase transition gives one count. The sequence AB = 00,10,11,01,00 (A leading) gives four counts with `cnt_up` = 1.
- R7: In mode 2'b01, only changes of A count, which gives two counts per full cycle.
- R8: In mode 2'b00, only changes of A while B is 0 count, which gives one count per full cycle in either direction.
- R9: The reverse sequence 00,01,11,10,00 (B leading) gives counts with `cnt_up` = 0. `cnt_up` holds its value between counts.
- R10: If A and B are accepted as changed at the same time, no count is produced.
- R11: `idx_valid` follows the filtered level of `quad_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| quad_a | input | 1 | Raw phase A |
| quad_b | input | 1 | Raw phase B |
| quad_idx | input | 1 | Raw index |
| psc_load | input | 1 | Load strobe for the divider value |
| psc_value | input | 8 | Divider value n |
| mode | input | 2 | Resolution: 00 one, 01 two, 10/11 four counts per cycle |
| cnt_en | output | 1 | One-cycle count pulse |
| cnt_up | output | 1 | Direction of the latest count, 1 = up |
| idx_valid | output | 1 | Filtered index level |

## Verification
The assertions assume that `mode` changes only while the filtered phases are steady. They also assume that a load strobe is never followed by a tick in the next cycle. The filter properties assume that a filtered line changes only after a full run of equal samples, so they hold for any input waveform. The stimulus holds each quadrature state for at least FILT_LEN+1 tick periods, which keeps it inside the accepted timing. Mode and divider changes are applied only between sequences, once the lines have settled. Glitches are deliberately kept at or below the rejected width.

// File: rtl/qf_pkg.sv
package qf_pkg;
  typedef enum logic [1:0] {
    QM_X1  = 2'b00,
    QM_X2  = 2'b01,
    QM_X4  = 2'b10,
    QM_X4B = 2'b11
  } qmode_e;
endpackage

// File: rtl/qf_prescale.sv
module qf_prescale #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PSC_W-1:0] value,
  output logic             tick
);
  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (load) begin
      div_q <= value;
      cnt_q <= value;
      tick  <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q <= div_q;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
      tick  <= 1'b0;
    end
  end

  // R2: with a ratio above zero, ticks never come back to back
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && div_q != '0) |=> !tick);
  // R3: a reload always restarts the division with no tick
  a_r3_reload_quiet: assert property (@(posedge clk) disable iff (rst)
    (load && value != '0) |=> (!tick ##1 !tick));
endmodule

// File: rtl/qf_filter.sv
module qf_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic dout
);
  logic              s1_q, s2_q;
  logic [FILT_LEN-1:0] hist_q;
  logic [FILT_LEN-1:0] window;

  assign window = {hist_q[FILT_LEN-2:0], s2_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      hist_q <= '0;
      dout   <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      if (tick) begin
        hist_q <= window;
        if (window == {FILT_LEN{s2_q}})
          dout <= s2_q;
      end
    end
  end

  // R4: the filtered level moves only with a full run of matching samples behind it
  a_r4_full_run: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> (hist_q == {FILT_LEN{dout}}));
  // R2: no movement without a sampling tick
  a_r2_tick_only: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(dout));
endmodule

// File: rtl/qf_decode.sv
module qf_decode
  import qf_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  qmode_e mode,
  input  logic   fa,
  input  logic   fb,
  output logic   cnt_en,
  output logic   cnt_up
);
  logic pa_q, pb_q;
  logic a_chg, b_chg, hit, up_nxt;

  assign a_chg = fa ^ pa_q;
  assign b_chg = fb ^ pb_q;

  always_comb begin
    hit    = 1'b0;
    up_nxt = cnt_up;
    if (a_chg && !b_chg) begin
      up_nxt = fa ^ pb_q;
      case (mode)
        QM_X1:   hit = !pb_q;
        default: hit = 1'b1;
      endcase
    end else if (b_chg && !a_chg) begin
      up_nxt = ~(fb ^ pa_q);
      hit    = (mode == QM_X4) || (mode == QM_X4B);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_q   <= 1'b0;
      pb_q   <= 1'b0;
      cnt_en <= 1'b0;
      cnt_up <= 1'b0;
    end else begin
      pa_q   <= fa;
      pb_q   <= fb;
      cnt_en <= hit;
      if (hit) cnt_up <= up_nxt;
    end
  end

  // R10: simultaneous change on both phases yields no count
  a_r10_double: assert property (@(posedge clk) disable iff (rst)
    (a_chg && b_chg) |=> !cnt_en);
  // R8: single resolution counts only A moves taken with B low
  a_r8_x1_gate: assert property (@(posedge clk) disable iff (rst)
    (!a_chg || pb_q) && mode == QM_X1 |=> !cnt_en);
  // R9: direction is held when no count is produced
  a_r9_dir_hold: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |-> $stable(cnt_up) || $past(rst));
endmodule

// File: rtl/qenc_front.sv
module qenc_front
  import qf_pkg::*;
#(
  parameter int PSC_W    = 8,
  parameter int FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             quad_a,
  input  logic             quad_b,
  input  logic             quad_idx,
  input  logic             psc_load,
  input  logic [PSC_W-1:0] psc_value,
  input  logic [1:0]       mode,
  output logic             cnt_en,
  output logic             cnt_up,
  output logic             idx_valid
);
  localparam int NUM_IN = 3;

  logic              tick;
  logic [NUM_IN-1:0] raw;
  logic [NUM_IN-1:0] filt;

  assign raw = {quad_idx, quad_b, quad_a};

  qf_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst   (rst),
    .load  (psc_load),
    .value (psc_value),
    .tick  (tick)
  );

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_flt
    qf_filter #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk  (clk),
      .rst  (rst),
      .tick (tick),
      .din  (raw[gi]),
      .dout (filt[gi])
    );
  end

  qf_decode u_dec (
    .clk    (clk),
    .rst    (rst),
    .mode   (qmode_e'(mode)),
    .fa     (filt[0]),
    .fb     (filt[1]),
    .cnt_en (cnt_en),
    .cnt_up (cnt_up)
  );

  assign idx_valid = filt[2];

  // R1: nothing is reported in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!cnt_en && !idx_valid));
  // R11: the index level moves only on a tick
  a_r11_idx_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(idx_valid));
endmodule

// File: tb/qenc_front_tb_top.sv
module qenc_front_tb_top;
  localparam int FL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic quad_a = 0, quad_b = 0, quad_idx = 0, psc_load = 0;
  logic [7:0] psc_value = 8'd0;
  logic [1:0] mode = 2'b10;
  logic cnt_en, cnt_up, idx_valid;

  int checks = 0, fails = 0, cycles = 0;
  int ups = 0, dns = 0;

  always #2 clk = ~clk;

  qenc_front #(.PSC_W(8), .FILT_LEN(FL)) dut_i (
    .clk(clk), .rst(rst), .quad_a(quad_a), .quad_b(quad_b), .quad_idx(quad_idx),
    .psc_load(psc_load), .psc_value(psc_value), .mode(mode),
    .cnt_en(cnt_en), .cnt_up(cnt_up), .idx_valid(idx_valid)
  );

  // behavioural reference model
  int  m_div, m_cnt, m_run [3];
  bit  m_tick, m_en, m_up, m_pa, m_pb;
  bit  m_s1 [3], m_s2 [3], m_last [3], m_f [3];
  int  po, pn, dlt;
  bit  ok;

  function automatic int gpos(bit a, bit b);
    if (!a && !b) return 0;
    if (a && !b)  return 1;
    if (a && b)   return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_cnt = 0; m_tick = 0; m_en = 0; m_up = 0; m_pa = 0; m_pb = 0;
      for (int i = 0; i < 3; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_last[i] = 0; m_f[i] = 0; m_run[i] = FL;
      end
    end else begin
      po = gpos(m_pa, m_pb);
      pn = gpos(m_f[0], m_f[1]);
      dlt = (pn - po + 4) % 4;
      m_en = 0;
      if (dlt == 1 || dlt == 3) begin
        if (mode == 2'b00)      ok = (m_f[0] != m_pa) && !m_f[1];
        else if (mode == 2'b01) ok = (m_f[0] != m_pa);
        else                    ok = 1;
        if (ok) begin m_en = 1; m_up = (dlt == 1); end
      end
      m_pa = m_f[0]; m_pb = m_f[1];
      if (m_tick)
        for (int i = 0; i < 3; i++) begin
          if (m_s2[i] == m_last[i]) begin if (m_run[i] < FL) m_run[i]++; end
          else begin m_last[i] = m_s2[i]; m_run[i] = 1; end
          if (m_run[i] >= FL) m_f[i] = m_last[i];
        end
      m_s2 = m_s1;
      m_s1[0] = quad_a; m_s1[1] = quad_b; m_s1[2] = quad_idx;
      if (psc_load) begin m_div = psc_value; m_cnt = psc_value; m_tick = 0; end
      else if (m_cnt == 0) begin m_cnt = m_div; m_tick = 1; end
      else begin m_cnt--; m_tick = 0; end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      checks++;
      if (cnt_en !== m_en) begin
        fails++; $display("FAIL R6 cnt_en actual %0b expected %0b", cnt_en, m_en);
      end else if (cnt_up !== m_up) begin
        fails++; $display("FAIL R9 cnt_up actual %0b expected %0b", cnt_up, m_up);
      end else if (idx_valid !== m_f[2]) begin
        fails++; $display("FAIL R11 idx_valid actual %0b expected %0b", idx_valid, m_f[2]);
      end
      if (cnt_en === 1'b1) begin
        if (cnt_up) ups++; else dns++;
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++; $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitn(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  int per = 1;

  task automatic put(bit a, bit b);
    quad_a = a; quad_b = b;
    waitn((FL + 1) * per + 4);
  endtask

  task automatic load(int n);
    psc_value = 8'(n); psc_load = 1; @(negedge clk); psc_load = 0;
    per = n + 1;
    waitn((FL + 2) * per + 6);
  endtask

  task automatic run_cycle(bit fwd, int exp_up, int exp_dn, string tag);
    int u0, d0;
    u0 = ups; d0 = dns;
    if (fwd) begin put(1,0); put(1,1); put(0,1); put(0,0); end
    else     begin put(0,1); put(1,1); put(1,0); put(0,0); end
    check({tag, " up counts"}, ups - u0, exp_up);
    check({tag, " down counts"}, dns - d0, exp_dn);
  endtask

  task automatic latency(output int j);
    j = 0;
    while (cnt_en !== 1'b1 && j < 100) begin @(negedge clk); j++; end
  endtask

  int u0, d0, lat;

  initial begin
    waitn(5);
    rst = 0;
    @(negedge clk);
    check("R1 cnt_en", int'(cnt_en), 0);
    check("R1 cnt_up", int'(cnt_up), 0);
    check("R1 idx_valid", int'(idx_valid), 0);
    waitn(10);

    mode = 2'b10;
    run_cycle(1, 4, 0, "R6 x4 fwd n0");
    run_cycle(0, 0, 4, "R9 x4 rev n0");
    check("R9 cnt_up held low", int'(cnt_up), 0);

    load(3);
    run_cycle(1, 4, 0, "R2 x4 fwd n3");
    mode = 2'b01;
    run_cycle(1, 2, 0, "R7 x2 fwd");
    run_cycle(0, 0, 2, "R7 x2 rev");
    mode = 2'b00;
    run_cycle(1, 1, 0, "R8 x1 fwd");
    run_cycle(0, 0, 1, "R8 x1 rev");

    mode = 2'b10;
    u0 = ups; d0 = dns;
    quad_a = 1; waitn((FL - 1) * per); quad_a = 0; waitn((FL + 2) * per + 6);
    quad_b = 1; waitn((FL - 1) * per); quad_b = 0; waitn((FL + 2) * per + 6);
    check("R4 glitch counts", (ups - u0) + (dns - d0), 0);

    quad_a = 1; quad_b = 1; waitn((FL + 2) * per + 6);
    quad_a = 0; quad_b = 0; waitn((FL + 2) * per + 6);
    check("R10 double transition counts", (ups - u0) + (dns - d0), 0);

    quad_idx = 1; waitn((FL + 2) * per + 6);
    check("R11 idx high", int'(idx_valid), 1);
    quad_idx = 0; waitn((FL - 1) * per);
    check("R11 idx after short low", int'(idx_valid), 1);
    quad_idx = 1; waitn((FL + 2) * per + 6);
    quad_idx = 0; waitn((FL + 2) * per + 6);
    check("R11 idx low", int'(idx_valid), 0);

    quad_a = 1;
    latency(lat);
    checks++;
    if (lat < 4 + (FL - 1) * per || lat > 4 + (per - 1) + (FL - 1) * per) begin
      fails++; $display("FAIL R5 latency actual %0d expected %0d..%0d", lat,
                        4 + (FL - 1) * per, 4 + (per - 1) + (FL - 1) * per);
    end
    waitn(4);
    quad_a = 0; waitn((FL + 2) * per + 6);

    psc_value = 8'd1; psc_load = 1; quad_a = 1;
    @(negedge clk); psc_load = 0;
    lat = 1;
    while (cnt_en !== 1'b1 && lat < 100) begin @(negedge clk); lat++; end
    check("R3 reload latency", lat, 9);
    per = 2;
    waitn(20);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule